// File: doc/BRIEF.md
# Time-Sliced Shared Bus Slot Arbiter

This block decides, clock by clock, who owns a single synchronous memory bus shared by the CPU and six DMA engines (disk, bitplane, copper, sprite, audio, blitter). The bus runs at twice the classic bus rate, and every clock is one slot. The slot type comes from the two low bits of the horizontal beam counter, `hslot`. Two slot types serve chip memory. A third is reserved for CPU fast memory. A fourth, non-standard, slot is shared between CPU fast-memory access and the blitter.

Each DMA engine raises a request, and with it a write flag and a hold flag. The hold flag asks for a dummy cycle: the engine holds the bus but does not move data. The arbiter picks at most one engine. Candidates are the engines allowed in the current slot, and among them a fixed priority decides. The arbiter registers the one-hot grant and three cycle-type flags. It lets the CPU through only when no DMA cycle is taking the slot and the slot suits the CPU's address class; otherwise it asserts the CPU wait output.

Read data returns over an OR-combined bus. Every unselected source drives zeros, so the returned word is the bitwise OR of all source words. The control outputs are registered: the decision for the slot presented before a rising edge appears just after that edge. The read bus is purely combinational. There is no valid/ready stream here: all pins are plain control and status.

Top module: `bus_slot_arbiter`

## Requirements
- R1: While `rst_n` is low, `grant`, `dma`, `dmawr`, `dmapri`, `cpu_go` and `cpu_wait` are all 0.
- R2: In slot `hslot`=00 no DMA engine is granted. A CPU fast request (`cpu_chip`=0) gets `cpu_go`=1, and a CPU chip request waits.
- R3: In slot 01 only disk, bitplane, copper and blitter may be granted. Sprite and audio requests are ignored.
- R4: In slot 10 only the blitter may be granted. When the blitter is not granted, a CPU fast request gets `cpu_go`=1.
- R5: In slot 11 only disk, bitplane, sprite and audio may be granted. Copper and blitter requests are ignored.
- R6: `grant` is one-hot or zero, with bit positions 0 disk, 1 bitplane, 2 copper, 3 sprite, 4 audio, 5 blitter. Among the eligible requesters, the lowest bit position wins.
- R7: `dma` is 1 exactly when some engine is granted. `dmapri` is 1 when the granted engine's hold flag is set. `dmawr` is 1 when the granted engine's write flag is set and its hold flag is clear.
- R8: `cpu_go` is 1 only when `dma` and `dmawr` are both 0. It also needs a matching slot: slots 00 and 10 for fast requests, slots 01 and 11 for chip requests.
- R9: `cpu_wait` equals `cpu_req` and not `cpu_go`. A chip request made in slot 00 or 10 keeps waiting until a free chip slot comes.
- R10: `rd_bus` is the bitwise OR of all `N_RD` words on `rd_src`. Word k is `rd_src[k*DW +: DW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| hslot | input | 2 | Low two bits of the horizontal beam counter (slot type) |
| dma_req | input | 6 | DMA requests, bit order as in R6 |
| dma_wr | input | 6 | Per-engine write flag |
| dma_hold | input | 6 | Per-engine dummy-hold flag |
| cpu_req | input | 1 | CPU bus request |
| cpu_chip | input | 1 | CPU address class: 1 chip, 0 fast |
| rd_src | input | N_RD*DW | Packed read words from all bus sources |
| grant | output | 6 | Registered one-hot DMA grant |
| dma | output | 1 | Registered: a DMA engine owns this slot |
| dmawr | output | 1 | Registered: the DMA cycle writes |
| dmapri | output | 1 | Registered: the DMA cycle is a dummy hold |
| cpu_go | output | 1 | Registered: the CPU may access this slot |
| cpu_wait | output | 1 | Registered: the CPU request is stalled |
| rd_bus | output | DW | OR of all read source words |

## Verification
The clocked properties check the registered outputs against the slot presented one edge earlier. They treat `hslot` as any value each cycle, not only an incrementing count. They read hold and write flags only through the granted engine, and place no limit on the flags of engines that are not requesting. The stimulus walks the beam counter both in order and in scrambled order. Requests, write and hold flags come from a free-running LFSR, and directed cases pin down each slot's eligibility and the priority ladder. The OR bus is driven with arbitrary, overlapping words. Its result is defined for any input, although in the system only one source is nonzero at a time.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  localparam int NSRC = 6;
  localparam int SRC_DISK   = 0;
  localparam int SRC_BPL    = 1;
  localparam int SRC_COPPER = 2;
  localparam int SRC_SPRITE = 3;
  localparam int SRC_AUDIO  = 4;
  localparam int SRC_BLIT   = 5;

  typedef enum logic [1:0] {
    SLOT_FAST   = 2'b00,
    SLOT_CHIP_A = 2'b01,
    SLOT_SHARED = 2'b10,
    SLOT_CHIP_B = 2'b11
  } slot_e;

  // Per source: bit n set means the source may take slot type n.
  function automatic logic [3:0] src_slots(int src);
    case (src)
      SRC_DISK, SRC_BPL: src_slots = 4'b1010;
      SRC_COPPER:        src_slots = 4'b0010;
      SRC_SPRITE, SRC_AUDIO: src_slots = 4'b1000;
      SRC_BLIT:          src_slots = 4'b0110;
      default:           src_slots = 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/bsa_slot_decode.sv
module bsa_slot_decode
  import bsa_pkg::*;
(
  input  logic [1:0]      hslot,
  output logic [NSRC-1:0] elig,
  output logic            chip_slot
);
  slot_e slot;
  assign slot = slot_e'(hslot);

  for (genvar s = 0; s < NSRC; s++) begin : g_elig
    localparam logic [3:0] PERMIT = src_slots(s);
    assign elig[s] = PERMIT[hslot];
  end

  assign chip_slot = (slot == SLOT_CHIP_A) || (slot == SLOT_CHIP_B);
endmodule

// File: rtl/bsa_pick.sv
module bsa_pick #(
  parameter int N = 6
) (
  input  logic [N-1:0] cand,
  output logic [N-1:0] win
);
  for (genvar i = 0; i < N; i++) begin : g_win
    if (i == 0) begin : g_first
      assign win[i] = cand[i];
    end else begin : g_rest
      assign win[i] = cand[i] & ~(|cand[i-1:0]);
    end
  end
endmodule

// File: rtl/bsa_or_bus.sv
module bsa_or_bus #(
  parameter int N_RD = 4,
  parameter int DW   = 16
) (
  input  logic [N_RD*DW-1:0] rd_src,
  output logic [DW-1:0]      rd_bus
);
  always_comb begin
    rd_bus = '0;
    for (int k = 0; k < N_RD; k++) rd_bus |= rd_src[k*DW +: DW];
  end
endmodule

// File: rtl/bus_slot_arbiter.sv
module bus_slot_arbiter
  import bsa_pkg::*;
#(
  parameter int N_RD = 4,
  parameter int DW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        hslot,
  input  logic [5:0]        dma_req,
  input  logic [5:0]        dma_wr,
  input  logic [5:0]        dma_hold,
  input  logic              cpu_req,
  input  logic              cpu_chip,
  input  logic [N_RD*DW-1:0] rd_src,
  output logic [5:0]        grant,
  output logic              dma,
  output logic              dmawr,
  output logic              dmapri,
  output logic              cpu_go,
  output logic              cpu_wait,
  output logic [DW-1:0]     rd_bus
);
  logic [NSRC-1:0] elig, win;
  logic            chip_slot;
  logic            n_dma, n_wr, n_pri, n_go;

  bsa_slot_decode u_dec (.hslot(hslot), .elig(elig), .chip_slot(chip_slot));
  bsa_pick #(.N(NSRC)) u_pick (.cand(dma_req & elig), .win(win));
  bsa_or_bus #(.N_RD(N_RD), .DW(DW)) u_bus (.rd_src(rd_src), .rd_bus(rd_bus));

  always_comb begin
    n_dma = |win;
    n_pri = |(win & dma_hold);
    n_wr  = |(win & dma_wr & ~dma_hold);
    n_go  = cpu_req && !n_dma && (cpu_chip == chip_slot);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant    <= '0;
      dma      <= 1'b0;
      dmawr    <= 1'b0;
      dmapri   <= 1'b0;
      cpu_go   <= 1'b0;
      cpu_wait <= 1'b0;
    end else begin
      grant    <= win;
      dma      <= n_dma;
      dmawr    <= n_wr;
      dmapri   <= n_pri;
      cpu_go   <= n_go;
      cpu_wait <= cpu_req && !n_go;
    end
  end

  // R6: grant is one-hot or idle
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  // R2: fast slot never gives DMA
  a_r2_fast_slot_no_dma: assert property (@(posedge clk) disable iff (!rst_n)
    (hslot == 2'b00) |=> (grant == 6'b0));
  // R3: first chip slot excludes sprite and audio
  a_r3_chip_a_set: assert property (@(posedge clk) disable iff (!rst_n)
    (hslot == 2'b01) |=> (grant[3] == 1'b0 && grant[4] == 1'b0));
  // R4: shared slot admits only the blitter
  a_r4_shared_blit_only: assert property (@(posedge clk) disable iff (!rst_n)
    (hslot == 2'b10) |=> (grant[4:0] == 5'b0));
  // R5: second chip slot excludes copper and blitter
  a_r5_chip_b_set: assert property (@(posedge clk) disable iff (!rst_n)
    (hslot == 2'b11) |=> (grant[2] == 1'b0 && grant[5] == 1'b0));
  // R7: a hold is a DMA cycle that does not write
  a_r7_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    dmapri |-> (dma && !dmawr));
  // R8: CPU only gets an idle slot
  a_r8_cpu_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_go |-> (!dma && !dmawr));
  // R9: a chip request in a fast slot waits
  a_r9_chip_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_chip && !hslot[0]) |=> (cpu_wait && !cpu_go));
endmodule

// File: tb/bus_slot_arbiter_test.sv
module bus_slot_arbiter_test;
  localparam int N_RD = 4;
  localparam int DW   = 16;

  typedef struct packed {
    logic [5:0] g;
    logic d, w, p, go, wt;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] hslot = '0;
  logic [5:0] dma_req = '0, dma_wr = '0, dma_hold = '0;
  logic cpu_req = 1'b0, cpu_chip = 1'b0;
  logic [N_RD*DW-1:0] rd_src = '0;
  logic [5:0] grant;
  logic dma, dmawr, dmapri, cpu_go, cpu_wait;
  logic [DW-1:0] rd_bus;

  int checks = 0, fails = 0;
  exp_t q[$];
  string tagq[$];
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  bus_slot_arbiter #(.N_RD(N_RD), .DW(DW)) uut (.*);

  function automatic exp_t model(logic [1:0] s, logic [5:0] rq, logic [5:0] wr,
                                 logic [5:0] hd, logic cr, logic cc);
    exp_t e;
    logic [5:0] el, c;
    case (s)
      2'b00: el = 6'b000000;
      2'b01: el = 6'b100111;
      2'b10: el = 6'b100000;
      default: el = 6'b011011;
    endcase
    c = rq & el;
    e = '0;
    for (int i = 5; i >= 0; i--) if (c[i]) e.g = 6'b1 << i;
    e.d  = (e.g != 0);
    e.p  = |(e.g & hd);
    e.w  = |(e.g & wr) && !e.p;
    e.go = cr && !e.d && (cc == s[0]);
    e.wt = cr && !e.go;
    return e;
  endfunction

  task automatic drive(logic [1:0] s, logic [5:0] rq, logic [5:0] wr, logic [5:0] hd,
                       logic cr, logic cc, string tag);
    @(negedge clk);
    hslot = s; dma_req = rq; dma_wr = wr; dma_hold = hd; cpu_req = cr; cpu_chip = cc;
    q.push_back(model(s, rq, wr, hd, cr, cc));
    tagq.push_back(tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e, a;
        string t;
        e = q.pop_front();
        t = tagq.pop_front();
        a = {grant, dma, dmawr, dmapri, cpu_go, cpu_wait};
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s: got g=%b d%b w%b p%b go%b wt%b expected g=%b d%b w%b p%b go%b wt%b",
                   t, a.g, a.d, a.w, a.p, a.go, a.wt, e.g, e.d, e.w, e.p, e.go, e.wt);
        end
      end
    end
  end

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk_bus(logic [DW-1:0] exp);
    #1;
    checks++;
    if (rd_bus !== exp) begin
      fails++;
      $display("FAIL R10: got %h expected %h", rd_bus, exp);
    end
  endtask

  initial begin
    // R1: reset holds outputs low even with activity
    dma_req = 6'h3F; cpu_req = 1'b1; hslot = 2'b01;
    repeat (3) @(negedge clk);
    checks++;
    if ({grant, dma, dmawr, dmapri, cpu_go, cpu_wait} !== 11'b0) begin
      fails++;
      $display("FAIL R1: got %b expected 0", {grant, dma, dmawr, dmapri, cpu_go, cpu_wait});
    end
    rst_n = 1'b1;
    dma_req = '0; cpu_req = 1'b0;

    // R2: fast slot
    drive(2'b00, 6'h3F, 6'h00, 6'h00, 1'b1, 1'b0, "R2 fast slot cpu fast");
    drive(2'b00, 6'h3F, 6'h00, 6'h00, 1'b1, 1'b1, "R2 fast slot chip waits");
    // R3: chip slot A ignores sprite/audio
    drive(2'b01, 6'b011000, 6'h00, 6'h00, 1'b1, 1'b1, "R3 sprite/audio ignored");
    drive(2'b01, 6'b100100, 6'h00, 6'h00, 1'b0, 1'b0, "R3 copper over blitter");
    // R4: shared slot
    drive(2'b10, 6'b011111, 6'h00, 6'h00, 1'b1, 1'b0, "R4 non-blitter ignored, cpu fast");
    drive(2'b10, 6'b100000, 6'b100000, 6'h00, 1'b1, 1'b0, "R4 blitter write");
    // R5: chip slot B
    drive(2'b11, 6'b100100, 6'h00, 6'h00, 1'b1, 1'b1, "R5 copper/blitter ignored");
    drive(2'b11, 6'b011000, 6'b001000, 6'h00, 1'b0, 1'b0, "R5 sprite over audio");
    // R6: priority ladder
    drive(2'b01, 6'b111111, 6'h00, 6'h00, 1'b0, 1'b0, "R6 disk first");
    drive(2'b11, 6'b011010, 6'h00, 6'h00, 1'b0, 1'b0, "R6 bitplane over sprite");
    drive(2'b11, 6'b010000, 6'h00, 6'h00, 1'b1, 1'b1, "R6 audio alone");
    // R7: hold and write flags of granted engine
    drive(2'b01, 6'b000011, 6'b000001, 6'b000001, 1'b1, 1'b1, "R7 hold suppresses write");
    drive(2'b01, 6'b000011, 6'b000010, 6'b000010, 1'b0, 1'b0, "R7 loser flags ignored");
    // R8/R9: chip request stalls through fast slots
    drive(2'b10, 6'h00, 6'h00, 6'h00, 1'b1, 1'b1, "R9 chip waits shared slot");
    drive(2'b11, 6'b000001, 6'h00, 6'h00, 1'b1, 1'b1, "R8 chip slot busy");
    drive(2'b00, 6'h00, 6'h00, 6'h00, 1'b1, 1'b1, "R9 chip waits fast slot");
    drive(2'b01, 6'h00, 6'h00, 6'h00, 1'b1, 1'b1, "R8 chip slot free");

    // random sweep, in-order and scrambled slots
    for (int n = 0; n < 600; n++) begin
      logic [1:0] s;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      s = (n < 300) ? n[1:0] : lfsr[9:8];
      drive(s, lfsr[5:0], lfsr[11:6], {lfsr[3], lfsr[14:10]} & {lfsr[1], lfsr[7:3]},
            lfsr[15], lfsr[2], "R7 random sweep");
    end

    // R10: OR bus
    @(negedge clk);
    rd_src = {16'h0000, 16'h0000, 16'h1234, 16'h0000};
    chk_bus(16'h1234);
    rd_src = {16'h8001, 16'h0F00, 16'h00F0, 16'h0003};
    chk_bus(16'h8FF3);
    rd_src = '0;
    chk_bus(16'h0000);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule